// File: doc/BRIEF.md
# Burst-of-four double-rate SRAM with split data ports

This block is a synchronous memory with one port that only delivers read data and another that only accepts write data. Both ports take their address from a single shared address bus. Reads and writes can therefore run at the same time, and no bus ever has to turn around. Every burst address selects four data words. Those words stream in order as four beats, one beat on each edge of a beat clock that runs at twice the command rate.

The command clock is modelled with the output `cmd_phase`. A read select is taken on beats where `cmd_phase` is 0, and a write select on beats where it is 1. Each select is active low and starts a four-beat burst of its own kind. A static mode input picks the read latency: one command cycle (two beats) or one and a half command cycles (three beats).

Read data leaves through a registered output stage. A read-valid strobe and an echo strobe mark the beats. Write beats pass through an input register and a commit register before they reach the array. A read that hits a word still held in that commit register returns the new bytes, so the memory always gives back the latest data.

Top module: `qdr4_sram`

## Requirements
- R1: While reset is held, `rvalid`, `echo`, `rdata` and `cmd_phase` are all 0.
- R2: `cmd_phase` is 0 on the first beat after reset and then inverts on every beat. Read selects are taken only on beats with `cmd_phase`=0, and write selects only on beats with `cmd_phase`=1. A select presented on the other phase is ignored.
- R3: A write taken at beat edge W stores `wdata` sampled at edges W+1..W+4 into words 0,1,2,3 of the burst at `addr`. The word address is `{addr, beat}`, where beat is 0..3 in order.
- R4: On each write beat, `wbe[i]`=1 writes bits 8i+7:8i of that word. `wbe[i]`=0 leaves that byte unchanged.
- R5: With `lat_full`=0, a read taken at edge E drives `rvalid`=1 from edge E+2 for exactly four beats, carrying words 0,1,2,3 in that order.
- R6: With `lat_full`=1, the same read burst starts at edge E+3 instead.
- R7: `echo` inverts at every edge that registers a read beat (`rvalid` becomes or stays 1). At every other edge it holds its value.
- R8: A select of the same kind that arrives while a burst is still running (two beats after it was taken) is ignored. An ignored read adds no beats. An ignored write changes no array contents.
- R9: Commands of one kind spaced exactly four beats apart are both accepted. Two reads spaced this way give eight contiguous valid beats.
- R10: A read taken one beat after a write to the same burst returns the new write data in both latency modes.
- R11: A read of one burst and a write of another run concurrently. The read returns the old contents, and the write completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_full | input | 1 | Static latency select: 1 = three beats, 0 = two beats |
| rd_n | input | 1 | Active-low read select |
| wr_n | input | 1 | Active-low write select |
| addr | input | ADDR_W | Shared burst address |
| wdata | input | DATA_W | Write beat data |
| wbe | input | DATA_W/BYTE_W | Per-byte write enables for the current beat |
| rdata | output | DATA_W | Read beat data |
| rvalid | output | 1 | High while a read beat is driven |
| echo | output | 1 | Inverts on each read beat |
| cmd_phase | output | 1 | Command phase of the next beat edge |

## Verification
Every burst address is first written with an arithmetic pattern that depends on both the address and the beat. All bursts are then read back in both latency modes, which exposes any address or beat-order error and any latency offset. Mixed byte-enable masks on single beats show whether the lanes are independent. Several timing patterns are then placed at the exact edges where acceptance is decided: selects on the wrong phase, selects held through a running burst, and commands spaced exactly four beats apart. These separate correct ignoring from both dropped and duplicated bursts. A read issued one beat after a write, first to the same burst and then to a different one, shows the difference between forwarding from the commit register and independent concurrent access.

// File: rtl/qdr4_pkg.sv
`timescale 1ns/1ps
package qdr4_pkg;
   localparam int unsigned BURST_LEN = 4;
   localparam int unsigned BEAT_W    = 2;
   localparam int unsigned CNT_W     = 3;

   typedef logic [BEAT_W-1:0] beat_t;
   typedef logic [CNT_W-1:0]  cnt_t;

   // beats still to go -> index of the beat issued now
   function automatic beat_t beat_of(cnt_t left);
      cnt_t idx;
      idx = cnt_t'(BURST_LEN) - left;
      return idx[BEAT_W-1:0];
   endfunction
endpackage

// File: rtl/qdr4_burst_seq.sv
`timescale 1ns/1ps
module qdr4_burst_seq
   import qdr4_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter bit          TAKE_PHASE = 1'b0,
   localparam int unsigned WORD_W    = ADDR_W + BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph,
   input  logic              sel_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              bv,
   output logic [WORD_W-1:0] bword
);
   cnt_t              left_q;
   logic [ADDR_W-1:0] base_q;
   logic              take;

   // accept on own phase when idle or on the final beat of the running burst
   always_comb take = (ph == TAKE_PHASE) && !sel_n && (left_q <= cnt_t'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         base_q <= '0;
         bv     <= 1'b0;
         bword  <= '0;
      end else begin
         if (take) begin
            left_q <= cnt_t'(BURST_LEN);
            base_q <= addr;
         end else if (left_q != '0) begin
            left_q <= left_q - cnt_t'(1);
         end
         bv    <= (left_q != '0);
         bword <= {base_q, beat_of(left_q)};
      end
   end
endmodule

// File: rtl/qdr4_lane.sv
`timescale 1ns/1ps
module qdr4_lane #(
   parameter int unsigned WORD_W = 6,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORDS = 2 ** WORD_W
) (
   input  logic              clk,
   input  logic              c_en,
   input  logic [WORD_W-1:0] c_word,
   input  logic [BYTE_W-1:0] c_data,
   input  logic              f_en,
   input  logic [WORD_W-1:0] f_word,
   input  logic [BYTE_W-1:0] f_data,
   input  logic [WORD_W-1:0] r_word,
   output logic [BYTE_W-1:0] r_data
);
   logic [BYTE_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (c_en) mem[c_word] <= c_data;
   end

   // newest in-flight byte wins, then the one being committed, then the array
   always_comb begin
      if (f_en && (f_word == r_word))      r_data = f_data;
      else if (c_en && (c_word == r_word)) r_data = c_data;
      else                                 r_data = mem[r_word];
   end
endmodule

// File: rtl/qdr4_sram.sv
`timescale 1ns/1ps
module qdr4_sram
   import qdr4_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NBYTES = DATA_W / BYTE_W,
   localparam int unsigned WORD_W = ADDR_W + BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lat_full,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NBYTES-1:0] wbe,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              echo,
   output logic              cmd_phase
);
   if (DATA_W % BYTE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of BYTE_W lanes");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("ADDR_W must lie in 1..10");
   end

   logic ph_q;
   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end
   assign cmd_phase = ph_q;

   // read side: beat requests, optional extra stage for the longer latency
   logic              r1_v, r2_v, rs_v;
   logic [WORD_W-1:0] r1_word, r2_word, rs_word;

   qdr4_burst_seq #(.ADDR_W(ADDR_W), .TAKE_PHASE(1'b0)) u_rseq (
      .clk(clk), .rst_n(rst_n), .ph(ph_q), .sel_n(rd_n), .addr(addr),
      .bv(r1_v), .bword(r1_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r2_v    <= 1'b0;
         r2_word <= '0;
      end else begin
         r2_v    <= r1_v;
         r2_word <= r1_word;
      end
   end

   always_comb begin
      rs_v    = lat_full ? r2_v    : r1_v;
      rs_word = lat_full ? r2_word : r1_word;
   end

   // write side: input register aligned with the sequencer, then commit stage
   logic              w1_v, w2_v;
   logic [WORD_W-1:0] w1_word, w2_word;
   logic [DATA_W-1:0] wd_q, w2_data;
   logic [NBYTES-1:0] wbe_q, w2_be;

   qdr4_burst_seq #(.ADDR_W(ADDR_W), .TAKE_PHASE(1'b1)) u_wseq (
      .clk(clk), .rst_n(rst_n), .ph(ph_q), .sel_n(wr_n), .addr(addr),
      .bv(w1_v), .bword(w1_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wd_q    <= '0;
         wbe_q   <= '0;
         w2_v    <= 1'b0;
         w2_word <= '0;
         w2_data <= '0;
         w2_be   <= '0;
      end else begin
         wd_q    <= wdata;
         wbe_q   <= wbe;
         w2_v    <= w1_v;
         w2_word <= w1_word;
         w2_data <= wd_q;
         w2_be   <= wbe_q;
      end
   end

   // byte lanes
   logic [DATA_W-1:0] rd_word_data;

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      qdr4_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
         .clk   (clk),
         .c_en  (w2_v & w2_be[g]),
         .c_word(w2_word),
         .c_data(w2_data[g*BYTE_W +: BYTE_W]),
         .f_en  (w1_v & wbe_q[g]),
         .f_word(w1_word),
         .f_data(wd_q[g*BYTE_W +: BYTE_W]),
         .r_word(rs_word),
         .r_data(rd_word_data[g*BYTE_W +: BYTE_W])
      );
   end

   // registered output stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
         echo   <= 1'b0;
      end else begin
         rvalid <= rs_v;
         if (rs_v) rdata <= rd_word_data;
         echo   <= echo ^ rs_v;
      end
   end
endmodule

// File: rtl/qdr4_sram_chk.sv
`timescale 1ns/1ps
module qdr4_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic lat_full,
   input logic rd_n,
   input logic cmd_phase,
   input logic rvalid,
   input logic echo
);
   logic       past_ok;
   logic [3:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
         run_q   <= '0;
      end else begin
         past_ok <= 1'b1;
         run_q   <= rvalid ? run_q + 4'd1 : 4'd0;
      end
   end

   a_r2_phase_alt: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (cmd_phase != $past(cmd_phase)));

   a_r7_echo_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rvalid) |-> (echo != $past(echo)));

   a_r7_echo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !rvalid) |-> (echo == $past(echo)));

   a_r5_start_short: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(rvalid) && !lat_full) |-> $past(!rd_n && !cmd_phase, 3));

   a_r6_start_long: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(rvalid) && lat_full) |-> $past(!rd_n && !cmd_phase, 4));

   a_r9_whole_bursts: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $fell(rvalid)) |-> (run_q[1:0] == 2'd0));
endmodule

bind qdr4_sram qdr4_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .lat_full(lat_full), .rd_n(rd_n),
   .cmd_phase(cmd_phase), .rvalid(rvalid), .echo(echo)
);

// File: tb/sim_qdr4_sram.sv
`timescale 1ns/1ps
module sim_qdr4_sram;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lat_full = 1'b0;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [NB-1:0] wbe = '0;
   logic [DW-1:0] rdata;
   logic          rvalid, echo, cmd_phase;

   qdr4_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .lat_full(lat_full), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid),
      .echo(echo), .cmd_phase(cmd_phase)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] ref_m [64];
   logic [DW-1:0] wd [4];
   logic [NB-1:0] wb [4];
   logic [DW-1:0] cap [12];
   int ncap, first, last, echo_bad;
   logic prev_echo;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic align(input bit p);
      while (cmd_phase !== p) step;
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return 16'(16'h5000 + a * 256 + k * 16 + (a ^ k));
   endfunction

   task automatic ref_apply(input int a, input int k, input logic [DW-1:0] d, input logic [NB-1:0] be);
      for (int b = 0; b < NB; b++)
         if (be[b]) ref_m[a*4+k][b*8 +: 8] = d[b*8 +: 8];
   endtask

   task automatic mon_reset;
      ncap = 0; first = -1; last = -1; echo_bad = 0; prev_echo = echo;
   endtask

   task automatic mon(input int i);
      if (rvalid === 1'b1) begin
         if (ncap < 12) cap[ncap] = rdata;
         ncap++;
         if (first < 0) first = i;
         last = i;
         if (echo === prev_echo) echo_bad++;
      end else if (echo !== prev_echo) begin
         echo_bad++;
      end
      prev_echo = echo;
   endtask

   task automatic wr_burst(input int a);
      align(1'b1);
      wr_n = 1'b0; addr = AW'(a);
      step;
      wr_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         wdata = wd[k]; wbe = wb[k];
         step;
         ref_apply(a, k, wd[k], wb[k]);
      end
      wbe = '0;
   endtask

   task automatic check_burst(input int a, input int base, input string tag);
      for (int k = 0; k < 4; k++)
         chk(cap[base+k] === ref_m[a*4+k], tag, 32'(cap[base+k]), 32'(ref_m[a*4+k]));
   endtask

   task automatic rd_burst(input int a, input string tag);
      align(1'b0);
      mon_reset;
      rd_n = 1'b0; addr = AW'(a);
      step;
      rd_n = 1'b1;
      for (int i = 1; i <= 8; i++) begin
         step;
         mon(i);
      end
      chk(first == (lat_full ? 3 : 2), {tag, " start"}, 32'(first), lat_full ? 3 : 2);
      chk(ncap == 4, {tag, " beats"}, 32'(ncap), 4);
      if (ncap == 4) check_burst(a, 0, tag);
      chk(echo_bad == 0, "R7 echo", 32'(echo_bad), 0);
   endtask

   task automatic fwd_case(input int wa, input int ra, input string tag);
      for (int k = 0; k < 4; k++) wd[k] = 16'(16'hC000 + wa * 64 + k + (lat_full ? 16'h0100 : 16'h0000));
      align(1'b1);
      wr_n = 1'b0; addr = AW'(wa);
      step;
      wr_n = 1'b1;
      mon_reset;
      rd_n = 1'b0; addr = AW'(ra); wdata = wd[0]; wbe = '1;
      for (int i = 1; i <= 9; i++) begin
         step;
         mon(i);
         rd_n = 1'b1;
         if (i < 4) wdata = wd[i];
      end
      wbe = '0;
      for (int k = 0; k < 4; k++) ref_apply(wa, k, wd[k], 2'b11);
      chk(first == (lat_full ? 4 : 3), {tag, " start"}, 32'(first), lat_full ? 4 : 3);
      chk(ncap == 4, {tag, " beats"}, 32'(ncap), 4);
      if (ncap == 4) check_burst(ra, 0, tag);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog all-requirements act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) step;
      // R1 reset state
      chk(rvalid === 1'b0, "R1 rvalid", 32'(rvalid), 0);
      chk(echo === 1'b0, "R1 echo", 32'(echo), 0);
      chk(rdata === '0, "R1 rdata", 32'(rdata), 0);
      chk(cmd_phase === 1'b0, "R1 cmd_phase", 32'(cmd_phase), 0);
      rst_n = 1'b1;
      // R2 phase alternation
      chk(cmd_phase === 1'b0, "R2 first phase", 32'(cmd_phase), 0);
      for (int i = 1; i <= 4; i++) begin
         step;
         chk(cmd_phase === 1'(i % 2), "R2 alternation", 32'(cmd_phase), 32'(i % 2));
      end

      // R3 sweep of all bursts, read in both latency modes (R5, R6)
      for (int a = 0; a < 16; a++) begin
         for (int k = 0; k < 4; k++) begin wd[k] = pat(a, k); wb[k] = 2'b11; end
         wr_burst(a);
      end
      lat_full = 1'b0;
      for (int a = 0; a < 16; a++) rd_burst(a, "R3 R5");
      lat_full = 1'b1;
      for (int a = 0; a < 16; a++) rd_burst(a, "R3 R6");

      // R4 per-byte enables
      wd[0] = 16'hA1B1; wd[1] = 16'hA2B2; wd[2] = 16'hA3B3; wd[3] = 16'hA4B4;
      wb[0] = 2'b01; wb[1] = 2'b10; wb[2] = 2'b00; wb[3] = 2'b11;
      wr_burst(5);
      lat_full = 1'b0; rd_burst(5, "R4");
      lat_full = 1'b1; rd_burst(5, "R4");

      // R2 selects on the wrong phase are ignored
      lat_full = 1'b0;
      align(1'b1);
      mon_reset;
      rd_n = 1'b0; addr = 4'd1;
      step;
      rd_n = 1'b1;
      for (int i = 1; i <= 8; i++) begin step; mon(i); end
      chk(ncap == 0, "R2 read on write phase", 32'(ncap), 0);
      align(1'b0);
      wr_n = 1'b0; addr = 4'd0;
      step;
      wr_n = 1'b1;
      for (int k = 0; k < 4; k++) begin wdata = 16'hDEAD; wbe = 2'b11; step; end
      wbe = '0;
      rd_burst(0, "R2 write on read phase");

      // R8 read select held through a running burst
      align(1'b0);
      mon_reset;
      rd_n = 1'b0; addr = 4'd2;
      step;
      for (int i = 1; i <= 10; i++) begin
         step;
         mon(i);
         if (i == 2) rd_n = 1'b1;
      end
      chk(ncap == 4, "R8 ignored read beats", 32'(ncap), 4);
      chk(first == 2, "R8 start", 32'(first), 2);
      if (ncap == 4) check_burst(2, 0, "R8");

      // R8 write select held through a running burst
      for (int k = 0; k < 4; k++) wd[k] = 16'(16'h7700 + k);
      align(1'b1);
      wr_n = 1'b0; addr = 4'd7;
      step;
      addr = 4'd9; wdata = wd[0]; wbe = 2'b11;
      step;
      wdata = wd[1];
      step;
      wr_n = 1'b1;
      wdata = wd[2]; step;
      wdata = wd[3]; step;
      wbe = '0;
      for (int k = 0; k < 4; k++) ref_apply(7, k, wd[k], 2'b11);
      rd_burst(9, "R8 ignored write");
      rd_burst(7, "R8 taken write");

      // R9 back-to-back writes
      for (int k = 0; k < 4; k++) wd[k] = 16'(16'h1A00 + k);
      align(1'b1);
      wr_n = 1'b0; addr = 4'd10;
      step;
      wr_n = 1'b1; wbe = 2'b11;
      for (int k = 0; k < 4; k++) begin
         wdata = wd[k];
         if (k == 3) begin wr_n = 1'b0; addr = 4'd11; end
         step;
         ref_apply(10, k, wd[k], 2'b11);
      end
      wr_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         wdata = 16'(16'h1B00 + k);
         step;
         ref_apply(11, k, 16'(16'h1B00 + k), 2'b11);
      end
      wbe = '0;
      rd_burst(10, "R9 first write");
      rd_burst(11, "R9 second write");

      // R9 back-to-back reads
      align(1'b0);
      mon_reset;
      rd_n = 1'b0; addr = 4'd3;
      step;
      for (int i = 1; i <= 12; i++) begin
         step;
         mon(i);
         if (i == 3) addr = 4'd4;
         if (i == 4) rd_n = 1'b1;
      end
      chk(ncap == 8, "R9 read beats", 32'(ncap), 8);
      chk(last - first == 7, "R9 contiguous", 32'(last - first), 7);
      if (ncap == 8) begin
         check_burst(3, 0, "R9 read one");
         check_burst(4, 4, "R9 read two");
      end
      chk(echo_bad == 0, "R7 echo back-to-back", 32'(echo_bad), 0);

      // R10 forwarding of an in-flight write, both modes
      lat_full = 1'b0; fwd_case(12, 12, "R10 short");
      lat_full = 1'b1; fwd_case(12, 12, "R10 long");

      // R11 concurrent read and write of different bursts
      lat_full = 1'b0; fwd_case(14, 13, "R11 concurrent read");
      rd_burst(14, "R11 concurrent write");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule